// File: doc/BRIEF.md
# Three-Deep Receive Message Buffer with Software Release

This block holds up to three received frames that an acceptance filter has already let through. It sits between a frame receiver and a register interface. The receiver pulses a store strobe together with a payload word that carries the identifier, the length and the data. The block keeps these words in arrival order and always presents the oldest one as an output mailbox.

Software reads one 32-bit status word. It holds a pending count, a sticky full flag, a sticky overrun flag and a release bit. Software writes a one to the release bit when it has finished with the mailbox. One cycle later the block drops that frame and shows the next frame, then clears the release bit by itself. The full and overrun flags are cleared by writing ones to them.

A configuration input sets what happens to a frame that arrives while all three slots are taken. The frame is either dropped or written over the newest stored frame.

Top module: `rx_mbox_fifo`

## Requirements
- R1: The pending count in status bits 1:0 takes values 0 to 3. It rises by one on every store strobe that is accepted while no release is completing.
- R2: A register write with bit 5 set makes status bit 5 read 1 in the following cycle. At the next clock edge the oldest frame is removed, the count falls by one, and bit 5 reads 0 again, unless a new write has set it. Writing 0 to bit 5 has no effect.
- R3: A release requested while the count is 0 leaves the count at 0 and the mailbox at 0.
- R4: The mailbox output shows the oldest stored frame and stays unchanged until that frame is released. It reads all zeros while the count is 0.
- R5: Status bit 3 (full) is set when an accepted store brings the count to 3. Writing 1 to bit 3 clears it, and writing 0 leaves it unchanged. When hardware sets it and software clears it in the same cycle, it ends up set.
- R6: Status bit 4 (overrun) is set when a frame arrives while 3 frames are held and no release completes in that cycle. It is cleared by writing 1 to bit 4, and a set in the same cycle wins over the clear.
- R7: On overrun with lock_mode_i = 1 the incoming frame is dropped. With lock_mode_i = 0 it replaces the newest stored frame. In both cases the count stays at 3 and the mailbox does not change.
- R8: When a store arrives in the same cycle as a release completes, the count stays the same and the mailbox moves on to the next frame. The new frame is accepted without setting overrun, even when 3 frames were held.
- R9: Status bit 2 and bits 31:6 always read 0, and the whole status word is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| store_i | input | 1 | Strobe: an accepted frame is present on frame_i |
| frame_i | input | FRAME_W | Frame payload (identifier, length, data) |
| lock_mode_i | input | 1 | 1: drop a frame on overrun; 0: overwrite the newest frame |
| reg_wr_i | input | 1 | Write strobe for the status register |
| reg_wdata_i | input | 32 | Write data: bit 5 requests a release, bits 3 and 4 clear their flags on 1 |
| status_o | output | 32 | Status word: count[1:0], full[3], overrun[4], release[5] |
| mbox_o | output | FRAME_W | Oldest stored frame, or zero when the buffer is empty |

## Verification
A wrong pointer or count shows up in the cycle right after the faulty edge. The mailbox then presents a frame out of order, a zero frame while the count is non-zero, or a count that disagrees with the number of stores minus the number of releases. A wrong flag decision shows up in the status word one cycle after the store or write that caused it. This is most visible at the three-frame boundary, where a store that coincides with a release must not set overrun and an unlocked overrun must change only the newest slot. The reference model follows the stored frames as an ordered queue, so it sees a bad overwrite slot two releases later, when that frame reaches the mailbox.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int STS_FULL_BIT = 3;
  localparam int STS_OVR_BIT  = 4;
  localparam int STS_REL_BIT  = 5;

  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  function automatic int unsigned wrap_dec(int unsigned p, int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

  function automatic int unsigned next_count(int unsigned c, bit push, bit pop);
    return c + 32'(push) - 32'(pop);
  endfunction
endpackage

// File: rtl/rxf_ptr_ctrl.sv
module rxf_ptr_ctrl #(
  parameter int DEPTH = 3,
  parameter int PW    = 2,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          store_i,
  input  logic          rel_pend_i,
  input  logic          lock_i,
  output logic [CW-1:0] count_o,
  output logic [PW-1:0] rd_ptr_o,
  output logic [PW-1:0] wr_addr_o,
  output logic          wr_en_o,
  output logic          push_o,
  output logic          pop_o,
  output logic          ovr_evt_o,
  output logic          full_evt_o
);
  import rxf_pkg::*;

  logic [CW-1:0] count_q;
  logic [PW-1:0] rd_q, wr_q;
  logic          at_full, empty, overwrite;

  assign at_full   = (count_q == CW'(DEPTH));
  assign empty     = (count_q == '0);
  assign pop_o     = rel_pend_i && !empty;
  assign push_o    = store_i && (!at_full || pop_o);
  assign ovr_evt_o = store_i && at_full && !pop_o;
  assign overwrite = ovr_evt_o && !lock_i;

  assign wr_en_o    = push_o || overwrite;
  assign wr_addr_o  = push_o ? wr_q : PW'(wrap_dec(32'(wr_q), DEPTH));
  assign full_evt_o = push_o && (next_count(32'(count_q), push_o, pop_o) == DEPTH);

  assign count_o  = count_q;
  assign rd_ptr_o = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
    end else begin
      count_q <= CW'(next_count(32'(count_q), push_o, pop_o));
      if (push_o) wr_q <= PW'(wrap_inc(32'(wr_q), DEPTH));
      if (pop_o)  rd_q <= PW'(wrap_inc(32'(rd_q), DEPTH));
    end
  end
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 3,
  parameter int PW    = 2,
  parameter int FW    = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_addr_i,
  input  logic [FW-1:0] wr_data_i,
  input  logic [PW-1:0] rd_addr_i,
  output logic [FW-1:0] rd_data_o
);
  logic [FW-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[i] <= '0;
      else if (wr_en_i && (wr_addr_i == PW'(i)))
        slot_q[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_addr_i == PW'(i)) rd_data_o = slot_q[i];
  end
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic          full_evt_i,
  input  logic          ovr_evt_i,
  input  logic [CW-1:0] count_i,
  output logic          rel_o,
  output logic [31:0]   status_o
);
  import rxf_pkg::*;

  logic full_q, ovr_q, rel_q;
  logic clr_full, clr_ovr, set_rel;
  logic unused_wbits;

  assign clr_full = reg_wr_i && reg_wdata_i[STS_FULL_BIT];
  assign clr_ovr  = reg_wr_i && reg_wdata_i[STS_OVR_BIT];
  assign set_rel  = reg_wr_i && reg_wdata_i[STS_REL_BIT];
  assign unused_wbits = ^{reg_wdata_i[31:6], reg_wdata_i[2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      full_q <= full_evt_i || (full_q && !clr_full);
      ovr_q  <= ovr_evt_i  || (ovr_q  && !clr_ovr);
      rel_q  <= set_rel;
    end
  end

  assign rel_o = rel_q;

  always_comb begin
    status_o               = '0;
    status_o[CW-1:0]       = count_i;
    status_o[STS_FULL_BIT] = full_q;
    status_o[STS_OVR_BIT]  = ovr_q;
    status_o[STS_REL_BIT]  = rel_q;
  end
endmodule

// File: rtl/rx_mbox_fifo.sv
module rx_mbox_fifo #(
  parameter int FRAME_W = 48,
  parameter int DEPTH   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               store_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               lock_mode_i,
  input  logic               reg_wr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        status_o,
  output logic [FRAME_W-1:0] mbox_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]      cnt;
  logic [PW-1:0]      rd_ptr, wr_addr;
  logic               wr_en, push, pop, ovr_evt, full_evt, rel_pend;
  logic [FRAME_W-1:0] head;

  rxf_ptr_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .store_i(store_i), .rel_pend_i(rel_pend),
    .lock_i(lock_mode_i), .count_o(cnt), .rd_ptr_o(rd_ptr),
    .wr_addr_o(wr_addr), .wr_en_o(wr_en), .push_o(push), .pop_o(pop),
    .ovr_evt_o(ovr_evt), .full_evt_o(full_evt)
  );

  rxf_store #(.DEPTH(DEPTH), .PW(PW), .FW(FRAME_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(frame_i), .rd_addr_i(rd_ptr), .rd_data_o(head)
  );

  rxf_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .full_evt_i(full_evt), .ovr_evt_i(ovr_evt), .count_i(cnt),
    .rel_o(rel_pend), .status_o(status_o)
  );

  assign mbox_o = (cnt != '0) ? head : '0;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int FRAME_W = 48,
  parameter int DEPTH   = 3,
  parameter int CW      = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rel_req,
  input logic               push,
  input logic               pop,
  input logic               ovr_evt,
  input logic               full_evt,
  input logic [CW-1:0]      count,
  input logic [31:0]        status,
  input logic [FRAME_W-1:0] mbox
);
  p_count_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_push_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |=> count == CW'($past(count) + 1'b1));

  p_pop_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push |=> count == CW'($past(count) - 1'b1));

  p_rel_self_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] && !rel_req |=> !status[5]);

  p_empty_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] && count == '0 && !push |=> count == '0);

  p_mbox_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pop && count != '0 |=> $stable(mbox));

  p_full_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full_evt |=> status[3]);

  p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> status[4]);

  p_ovr_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> count == CW'(DEPTH));

  p_swap_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop |=> count == $past(count));

  p_swap_no_ovr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !ovr_evt);
endmodule

bind rx_mbox_fifo rxf_checker #(.FRAME_W(FRAME_W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rel_req(reg_wr_i & reg_wdata_i[5]),
  .push(push), .pop(pop), .ovr_evt(ovr_evt), .full_evt(full_evt),
  .count(cnt), .status(status_o), .mbox(mbox_o)
);

// File: tb/test_rx_mbox_fifo.sv
module test_rx_mbox_fifo;
  localparam int FW = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          store_i = 1'b0;
  logic [FW-1:0] frame_i = '0;
  logic          lock_mode_i = 1'b1;
  logic          reg_wr_i = 1'b0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   status_o;
  logic [FW-1:0] mbox_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rx_mbox_fifo #(.FRAME_W(FW), .DEPTH(3)) i_rx_mbox_fifo (
    .clk(clk), .rst_n(rst_n), .store_i(store_i), .frame_i(frame_i),
    .lock_mode_i(lock_mode_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .status_o(status_o), .mbox_o(mbox_o)
  );

  // Behavioural reference: ordered queue of frames plus three flag bits
  logic [FW-1:0] m_q[$];
  bit m_full, m_ovr, m_rel;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete();
      m_full = 0; m_ovr = 0; m_rel = 0;
    end else begin
      bit popped;
      popped = m_rel && (m_q.size() > 0);
      if (reg_wr_i && reg_wdata_i[3]) m_full = 0;
      if (reg_wr_i && reg_wdata_i[4]) m_ovr = 0;
      if (popped) void'(m_q.pop_front());
      if (store_i) begin
        if (m_q.size() < 3) begin
          m_q.push_back(frame_i);
          if (m_q.size() == 3) m_full = 1;
        end else begin
          m_ovr = 1;
          if (!lock_mode_i) m_q[2] = frame_i;
        end
      end
      m_rel = reg_wr_i && reg_wdata_i[5];
    end
  end

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    logic [FW-1:0] exp_mb;
    exp_mb = (m_q.size() > 0) ? m_q[0] : '0;
    check(status_o[1:0] == 2'(m_q.size()), "R1 count", 64'(status_o[1:0]), 64'(m_q.size()));
    check(status_o[5] == m_rel, "R2 release bit", 64'(status_o[5]), 64'(m_rel));
    check(mbox_o == exp_mb, "R4 mailbox", 64'(mbox_o), 64'(exp_mb));
    check(status_o[3] == m_full, "R5 full", 64'(status_o[3]), 64'(m_full));
    check(status_o[4] == m_ovr, "R6 overrun", 64'(status_o[4]), 64'(m_ovr));
    check((status_o & ~32'h3B) == 0, "R9 reserved bits", 64'(status_o), 64'(status_o & 32'h3B));
  endtask

  // inputs are set at a negedge; tick lets one edge pass and compares
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_model();
    store_i = 0; reg_wr_i = 0; reg_wdata_i = '0;
  endtask

  task automatic put(logic [FW-1:0] f);
    store_i = 1; frame_i = f; tick();
  endtask

  task automatic wr(logic [31:0] d);
    reg_wr_i = 1; reg_wdata_i = d; tick();
  endtask

  function automatic logic [FW-1:0] fr(int k);
    return FW'(48'h0A0000000000 + 48'(k) * 48'h10101);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(status_o == 0, "R9 reset status", 64'(status_o), 0);
    check(mbox_o == 0, "R4 reset mailbox", 64'(mbox_o), 0);
    rst_n = 1;
    tick();

    // fill to three: count and full
    put(fr(1)); put(fr(2)); put(fr(3));
    check(status_o[1:0] == 3, "R1 count at three", 64'(status_o[1:0]), 3);
    check(status_o[3] == 1, "R5 full on third store", 64'(status_o[3]), 1);
    wr(32'h0);
    check(status_o[3] == 1, "R5 write zero keeps full", 64'(status_o[3]), 1);

    // locked overrun drops the frame
    lock_mode_i = 1;
    put(fr(4));
    check(status_o[4] == 1, "R6 overrun set", 64'(status_o[4]), 1);
    check(mbox_o == fr(1), "R7 locked mailbox unchanged", 64'(mbox_o), 64'(fr(1)));
    wr(32'h18);
    check(status_o[4:3] == 0, "R6 write one clears flags", 64'(status_o[4:3]), 0);

    // unlocked overrun replaces newest (frame 3 -> frame 5)
    lock_mode_i = 0;
    put(fr(5));
    check(status_o[1:0] == 3, "R7 count stays three", 64'(status_o[1:0]), 3);
    wr(32'h20);
    check(status_o[5] == 1, "R2 release bit reads one", 64'(status_o[5]), 1);
    tick();
    check(status_o[5] == 0, "R2 release bit self clears", 64'(status_o[5]), 0);
    check(mbox_o == fr(2), "R2 next frame after release", 64'(mbox_o), 64'(fr(2)));
    wr(32'h20); tick();
    check(mbox_o == fr(5), "R7 overwritten newest frame", 64'(mbox_o), 64'(fr(5)));
    wr(32'h20); tick();
    check(status_o[1:0] == 0, "R2 drained", 64'(status_o[1:0]), 0);

    // release while empty
    wr(32'h20); tick();
    check(status_o[1:0] == 0, "R3 empty release count", 64'(status_o[1:0]), 0);
    check(mbox_o == 0, "R3 empty release mailbox", 64'(mbox_o), 0);

    // store coinciding with release at three frames
    wr(32'h10);
    lock_mode_i = 1;
    put(fr(6)); put(fr(7)); put(fr(8));
    wr(32'h20);
    put(fr(9));
    check(status_o[1:0] == 3, "R8 count unchanged on swap", 64'(status_o[1:0]), 3);
    check(status_o[4] == 0, "R8 no overrun on swap", 64'(status_o[4]), 0);
    check(mbox_o == fr(7), "R8 mailbox advanced", 64'(mbox_o), 64'(fr(7)));

    // full set and cleared in the same cycle: set wins
    wr(32'h28); tick();
    store_i = 1; frame_i = fr(10); reg_wr_i = 1; reg_wdata_i = 32'h08; tick();
    check(status_o[3] == 1, "R5 set wins over clear", 64'(status_o[3]), 1);

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      if (n % 97 == 0) lock_mode_i = $urandom_range(0, 1) == 1;
      store_i = ($urandom_range(0, 9) < 4);
      frame_i = FW'({$urandom(), $urandom()});
      reg_wr_i = ($urandom_range(0, 9) < 3);
      reg_wdata_i = $urandom() & 32'hFFFF_FFFF;
      @(posedge clk);
      @(negedge clk);
      compare_model();
    end
    store_i = 0; reg_wr_i = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule